// File: doc/BRIEF.md
# Seedable Linear Feedback Shift Register Generator

This block produces a pseudo-random word from a linear feedback shift register whose shape is fixed when it is built. Parameters select the register width, the tap mask, the feedback form (a single reduced feedback bit entering at the top, or the outgoing bit folded into every tapped position), the feedback polarity (XOR or XNOR), an optional reset seed, the number of shifts made per enabled increment, and whether a run-time seed is advanced as it is loaded. The whole state word is driven onto the output every cycle.

Software or a neighbouring block steps the generator with an increment enable and may replace its state at any time through a seed port made of a valid strobe and a data word. A seed load beats an increment that arrives in the same cycle. Reset is synchronous and active-high. Reset never places the register in its lock-up word, which is all zeros under XOR feedback and all ones under XNOR feedback. A build with a width or step below one is refused when it is elaborated. So is a build whose reset seed equals the lock-up word.

With its default parameters the block reproduces a legacy 16-bit generator. That generator resets to 1 and shifts right by one place per increment. The bit that enters at the top is the XOR of state bits 0, 2, 3 and 5.

Top module: `lfsr_gen`

## Requirements
- R1: A synchronous reset loads the configured reset seed, which is 1 by default. With no reset seed configured, reset loads 1 under XOR feedback and 0 under XNOR feedback, so the word after reset is never the lock-up word.
- R2: In the default build each enabled increment sets the state to {s[0]^s[2]^s[3]^s[5], s[15:1]}.
- R3: When neither the increment enable nor the seed valid is high, the state holds.
- R4: With seed advancing off, a seed valid pulse places the seed word unchanged on the output in the next cycle, whatever the increment enable is doing.
- R5: With seed advancing on, a seed valid pulse places the seed advanced by one increment on the output in the next cycle.
- R6: With a step of N, one enabled increment gives the state that N single shifts would give.
- R7: Once the lock-up word is loaded through the seed port, the output stays at it under any number of increments until reset. After reset the output differs from it.
- R8: In the Galois form, an increment shifts the state right by one place, moves bit 0 into the top bit, and combines bit 0 by XOR (or XNOR) into each lower position i whose tap mask bit i is set.
- R9: With maximal-period taps, the state first returns to its starting word after exactly 2^width - 1 increments. This is checked for the 16-bit default build and for a 4-bit Galois XNOR build with tap mask 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| incr_en | input | 1 | Advance the register by one increment |
| seed_vld | input | 1 | Load the seed word this cycle (has priority over incr_en) |
| seed_val | input | WIDTH | Seed word to load |
| state_out | output | WIDTH | Current register state |

## Verification
A seed load and an increment can fall in the same cycle. The bench provokes this by raising seed_vld and incr_en together in a vector-table row on the default build and again on the seed-advancing Galois build. It judges the result by the output one cycle later. That output must equal the seed (or the seed advanced once) and not the advanced old state. The lock-up cases check the same collision with the all-zeros and all-ones seeds, followed by further increments.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;

    // Where feedback enters the register.
    typedef enum logic {
        FORM_FIBONACCI = 1'b0,  // taps reduced to one bit entering the MSB
        FORM_GALOIS    = 1'b1   // outgoing LSB folded into each tapped bit
    } lfsr_form_e;

    // Polarity of the feedback combination.
    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } lfsr_fb_e;

    // Source of the next register value.
    typedef enum logic [1:0] {
        NXT_HOLD = 2'd0,
        NXT_ADV  = 2'd1,
        NXT_SEED = 2'd2
    } lfsr_nxt_e;

    // Combine two bits with the selected polarity.
    function automatic logic fb_combine(input lfsr_fb_e fb, input logic a, input logic b);
        return (fb == FB_XNOR) ? ~(a ^ b) : (a ^ b);
    endfunction

endpackage

// File: rtl/lfsr_shift1.sv
`timescale 1ns/1ps
// One right shift of the register in the selected form and polarity.
module lfsr_shift1 import lfsr_pkg::*; #(
    parameter int               WIDTH = 16,
    parameter lfsr_form_e       FORM  = FORM_FIBONACCI,
    parameter lfsr_fb_e         FB    = FB_XOR,
    parameter logic [WIDTH-1:0] TAPS  = WIDTH'(1)
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    if (FORM == FORM_FIBONACCI) begin : g_fib
        logic par;
        assign par = ^(din & TAPS);
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == WIDTH - 1) begin : g_top
                assign dout[i] = (FB == FB_XNOR) ? ~par : par;
            end else begin : g_mid
                assign dout[i] = din[i+1];
            end
        end
    end else begin : g_gal
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == WIDTH - 1) begin : g_top
                assign dout[i] = din[0];
            end else if (TAPS[i]) begin : g_tap
                assign dout[i] = fb_combine(FB, din[i+1], din[0]);
            end else begin : g_pass
                assign dout[i] = din[i+1];
            end
        end
    end

endmodule

// File: rtl/lfsr_advance.sv
`timescale 1ns/1ps
// STEP single shifts chained into one combinational increment.
module lfsr_advance import lfsr_pkg::*; #(
    parameter int               WIDTH = 16,
    parameter int               STEP  = 1,
    parameter lfsr_form_e       FORM  = FORM_FIBONACCI,
    parameter lfsr_fb_e         FB    = FB_XOR,
    parameter logic [WIDTH-1:0] TAPS  = WIDTH'(1)
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [STEP+1];

    assign stage[0] = din;

    for (genvar k = 0; k < STEP; k++) begin : g_stage
        lfsr_shift1 #(
            .WIDTH (WIDTH),
            .FORM  (FORM),
            .FB    (FB),
            .TAPS  (TAPS)
        ) u_shift (
            .din  (stage[k]),
            .dout (stage[k+1])
        );
    end

    assign dout = stage[STEP];

endmodule

// File: rtl/lfsr_gen.sv
`timescale 1ns/1ps
module lfsr_gen import lfsr_pkg::*; #(
    parameter int               WIDTH          = 16,
    parameter int               STEP           = 1,
    parameter lfsr_form_e       FORM           = FORM_FIBONACCI,
    parameter lfsr_fb_e         FB             = FB_XOR,
    parameter logic [WIDTH-1:0] TAPS           = WIDTH'(16'h002D),
    parameter bit               HAS_RESET_SEED = 1'b1,
    parameter logic [WIDTH-1:0] RESET_SEED     = WIDTH'(1),
    parameter bit               UPDATE_SEED    = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             incr_en,
    input  logic             seed_vld,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] state_out
);

    localparam logic [WIDTH-1:0] LOCKUP      = (FB == FB_XNOR) ? '1 : '0;
    localparam logic [WIDTH-1:0] FALLBACK    = (FB == FB_XNOR) ? '0 : WIDTH'(1);
    localparam logic [WIDTH-1:0] RESET_STATE = HAS_RESET_SEED ? RESET_SEED : FALLBACK;

    if (WIDTH < 1) begin : g_bad_width
        $error("lfsr_gen: WIDTH must be at least 1");
    end
    if (STEP < 1) begin : g_bad_step
        $error("lfsr_gen: STEP must be at least 1");
    end
    if (HAS_RESET_SEED && (RESET_SEED == LOCKUP)) begin : g_bad_seed
        $error("lfsr_gen: RESET_SEED equals the lock-up word");
    end

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_adv;
    logic [WIDTH-1:0] seed_in;
    logic [WIDTH-1:0] state_d;
    lfsr_nxt_e        nxt_sel;

    lfsr_advance #(
        .WIDTH (WIDTH), .STEP (STEP), .FORM (FORM), .FB (FB), .TAPS (TAPS)
    ) u_adv_state (
        .din  (state_q),
        .dout (state_adv)
    );

    if (UPDATE_SEED) begin : g_seed_adv
        lfsr_advance #(
            .WIDTH (WIDTH), .STEP (STEP), .FORM (FORM), .FB (FB), .TAPS (TAPS)
        ) u_adv_seed (
            .din  (seed_val),
            .dout (seed_in)
        );
    end else begin : g_seed_raw
        assign seed_in = seed_val;
    end

    always_comb begin
        if (seed_vld)     nxt_sel = NXT_SEED;
        else if (incr_en) nxt_sel = NXT_ADV;
        else              nxt_sel = NXT_HOLD;
    end

    always_comb begin
        unique case (nxt_sel)
            NXT_SEED: state_d = seed_in;
            NXT_ADV:  state_d = state_adv;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RESET_STATE;
        else     state_q <= state_d;
    end

    assign state_out = state_q;

endmodule

// File: rtl/lfsr_gen_chk.sv
`timescale 1ns/1ps
module lfsr_gen_chk import lfsr_pkg::*; #(
    parameter int         WIDTH       = 16,
    parameter int         STEP        = 1,
    parameter lfsr_form_e FORM        = FORM_FIBONACCI,
    parameter lfsr_fb_e   FB          = FB_XOR,
    parameter bit         UPDATE_SEED = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             incr_en,
    input logic             seed_vld,
    input logic [WIDTH-1:0] seed_val,
    input logic [WIDTH-1:0] state_out
);

    localparam logic [WIDTH-1:0] LOCKUP = (FB == FB_XNOR) ? '1 : '0;

    // R1
    reset_not_lockup_chk: assert property (@(posedge clk)
        rst |=> (state_out != LOCKUP));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!incr_en && !seed_vld) |=> $stable(state_out));

    // R4
    seed_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_vld && !UPDATE_SEED) |=> (state_out == $past(seed_val)));

    // R7
    lockup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_out == LOCKUP && !seed_vld) |=> (state_out == LOCKUP));

    if (FORM == FORM_FIBONACCI && STEP == 1 && WIDTH > 1) begin : g_fib_shift
        // R2
        fib_shift_chk: assert property (@(posedge clk) disable iff (rst)
            (incr_en && !seed_vld) |=>
                (state_out[WIDTH-2:0] == $past(state_out[WIDTH-1:1])));
    end

    if (FORM == FORM_GALOIS && STEP == 1) begin : g_gal_top
        // R8
        gal_top_chk: assert property (@(posedge clk) disable iff (rst)
            (incr_en && !seed_vld) |=> (state_out[WIDTH-1] == $past(state_out[0])));
    end

endmodule

bind lfsr_gen lfsr_gen_chk #(
    .WIDTH       (WIDTH),
    .STEP        (STEP),
    .FORM        (FORM),
    .FB          (FB),
    .UPDATE_SEED (UPDATE_SEED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .incr_en   (incr_en),
    .seed_vld  (seed_vld),
    .seed_val  (seed_val),
    .state_out (state_out)
);

// File: tb/tb_lfsr_gen.sv
`timescale 1ns/1ps
module tb_lfsr_gen;
    import lfsr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    // default (legacy 16-bit) build
    logic        a_inc = 0, a_ld = 0;
    logic [15:0] a_seed = '0, a_q;
    // 4-bit Galois XNOR, no reset seed, seed advancing
    logic        g_inc = 0, g_ld = 0;
    logic [3:0]  g_seed = '0, g_q;
    // 16-bit legacy taps, three shifts per increment
    logic        s_inc = 0, s_ld = 0;
    logic [15:0] s_seed = '0, s_q;

    lfsr_gen dut (.clk(clk), .rst(rst), .incr_en(a_inc), .seed_vld(a_ld),
                  .seed_val(a_seed), .state_out(a_q));

    lfsr_gen #(.WIDTH(4), .STEP(1), .FORM(FORM_GALOIS), .FB(FB_XNOR),
               .TAPS(4'b0100), .HAS_RESET_SEED(1'b0), .RESET_SEED(4'b0001),
               .UPDATE_SEED(1'b1))
        dut_g (.clk(clk), .rst(rst), .incr_en(g_inc), .seed_vld(g_ld),
               .seed_val(g_seed), .state_out(g_q));

    lfsr_gen #(.STEP(3))
        dut_s (.clk(clk), .rst(rst), .incr_en(s_inc), .seed_vld(s_ld),
               .seed_val(s_seed), .state_out(s_q));

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [15:0] ref16(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    function automatic logic [3:0] refg4(input logic [3:0] s);
        return {s[0], ~(s[3] ^ s[0]), s[2], s[1]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample just after it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a_inc = 0; a_ld = 0; g_inc = 0; g_ld = 0; s_inc = 0; s_ld = 0;
        tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    // {load, incr, seed[15:0], expected[15:0], req[3:0]}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h0000, 16'h8000, 4'd2},  // R2 from reset word 1
        {1'b0, 1'b0, 16'h1234, 16'h8000, 4'd3},  // R3 idle holds
        {1'b0, 1'b1, 16'h0000, 16'h4000, 4'd2},  // R2
        {1'b1, 1'b1, 16'h0021, 16'h0021, 4'd4},  // R4 load beats increment
        {1'b0, 1'b1, 16'h0000, 16'h0010, 4'd2},  // R2 feedback cancels
        {1'b0, 1'b1, 16'h0000, 16'h0008, 4'd2},  // R2
        {1'b0, 1'b1, 16'h0000, 16'h8004, 4'd2},  // R2 bit3 feeds MSB
        {1'b0, 1'b0, 16'hFFFF, 16'h8004, 4'd3},  // R3
        {1'b1, 1'b0, 16'h00FF, 16'h00FF, 4'd4},  // R4 plain load
        {1'b0, 1'b1, 16'h0000, 16'h007F, 4'd2}   // R2 even parity
    };

    initial begin : watchdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] exp;
        logic [3:0]  gstart;
        int          cnt;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset values
        chk("R1 default seed", a_q, 16'h0001);
        chk("R1 xnor fallback", {12'h0, g_q}, 16'h0000);
        chk("R1 step build", s_q, 16'h0001);

        // vector table on the default build
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            a_ld   = VEC[v][37];
            a_inc  = VEC[v][36];
            a_seed = VEC[v][35:20];
            tick();
            chk($sformatf("R%0d vec %0d", VEC[v][3:0], v), a_q, VEC[v][19:4]);
        end
        @(negedge clk);
        a_ld = 0; a_inc = 0;

        // R6: one increment of a step-3 build equals three single shifts
        do_reset();
        exp = 16'h0001;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            s_inc = 1;
            tick();
            exp = ref16(ref16(ref16(exp)));
            chk("R6 step 3", s_q, exp);
        end
        @(negedge clk);
        s_inc = 0;

        // R8: Galois XNOR shifts from reset word 0
        @(negedge clk);
        g_inc = 1;
        tick();
        chk("R8 galois 1st", {12'h0, g_q}, 16'h0004);
        tick();
        chk("R8 galois 2nd", {12'h0, g_q}, 16'h0006);

        // R5: seed advancing, load collides with increment
        @(negedge clk);
        g_ld = 1; g_seed = 4'b0011; g_inc = 1;
        tick();
        chk("R5 seed advanced", {12'h0, g_q}, {12'h0, refg4(4'b0011)});

        // R9: 4-bit Galois period
        @(negedge clk);
        g_ld = 0;
        gstart = g_q;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            cnt++;
            if (g_q == gstart) break;
        end
        chk("R9 galois period", 16'(cnt), 16'd15);
        @(negedge clk);
        g_inc = 0;

        // R9: 16-bit legacy period
        do_reset();
        a_inc = 1;
        cnt = 0;
        for (int k = 0; k < 70000; k++) begin
            tick();
            cnt++;
            if (a_q == 16'h0001) break;
        end
        chk("R9 legacy period", 16'(cnt), 16'hFFFF);
        @(negedge clk);
        a_inc = 0;

        // R7: lock-up words are sticky until reset
        @(negedge clk);
        a_ld = 1; a_seed = 16'h0000; a_inc = 1;
        g_ld = 1; g_seed = 4'hF;     g_inc = 1;
        tick();
        @(negedge clk);
        a_ld = 0; g_ld = 0;
        repeat (3) tick();
        chk("R7 xor lockup held", a_q, 16'h0000);
        chk("R7 xnor lockup held", {12'h0, g_q}, 16'h000F);
        do_reset();
        #2;
        chk("R7 xor after reset", a_q, 16'h0001);
        chk("R7 xnor after reset", {12'h0, g_q}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule